// File: doc/BRIEF.md
# Fill-Error Capture and Interrupt Unit

This unit watches for bus errors reported on memory-fill transactions, the reads a cache issues toward main memory. When a failed fill was issued on behalf of a processor write miss rather than a processor read, the unit records the byte address of the affected line and the source ID of the requester. If interrupts are enabled, it then raises an interrupt. A failed fill that belongs to a processor read raises no interrupt. It is instead signalled on a separate one-cycle error-response strobe, so the read can be answered with an error.

Only one error is held at a time. While a captured error waits for software, any further error events are dropped. The unit never stalls waiting for an acknowledge, which rules out deadlock. Software uses a small register window on a simple request/response target bus to enable the interrupt, read the captured address and source ID, and acknowledge the error. The acknowledge is a read of a dedicated register.

Top module: `fill_error_irq`

## Requirements
- R1: After a synchronous active-low reset, the interrupt output, the response-valid output and the error-response strobe are low. No error is pending and interrupts are disabled, so a fill error arriving before any enable write is not captured, and the low-address register then reads 0.
- R2: An event with valid high, fill flag high and processor-read flag low is captured when interrupts are enabled and no error is pending. The pending state and the interrupt are visible from the clock edge that samples the event.
- R3: The captured byte address equals the line number times words-per-line times 4. Register index 0 returns its bits 31:0 and index 1 returns bits 63:32, zero-extended.
- R4: The requester source ID is latched with the address, and register index 2 returns it zero-extended to 32 bits.
- R5: While an error is pending, further fill-error events are dropped. The captured address and source ID stay unchanged.
- R6: An event is ignored when interrupts are disabled or when its fill flag is low.
- R7: An event with the processor-read flag high is never captured. Instead, `proc_err_o` pulses high for one cycle, starting at the clock edge that samples the event.
- R8: `irq_o` is high exactly when an error is pending and interrupts are enabled. Disabling interrupts hides a pending error without discarding it.
- R9: A read of index 3 clears the pending error and returns data 0 with no error flag.
- R10: Index 4 is the only writable register. Writing it sets the enable to 1 for nonzero data and to 0 for zero data, and the response carries no error.
- R11: The register address is formed as function code in bits [9:7], reserved bits [6:3] and index in bits [2:0]. The response error flag is raised for any of these: a function code other than 2; nonzero reserved bits; a write to an index other than 4; a read of index 4 to 7.
- R12: Every register request gets exactly one response, on the cycle after the request, and there is no response without a request.
- R13: When an index-3 read and a capturable event arrive in the same cycle, the clear wins. The event is dropped, and the previous captured address remains readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid_i | input | 1 | Fill-error event strobe |
| evt_line_i | input | LINE_W | Line number of the failed transaction |
| evt_srcid_i | input | SRC_W | Source ID of the owning requester |
| evt_fill_i | input | 1 | Transaction was a fill from memory |
| evt_proc_read_i | input | 1 | Transaction serves a processor read |
| reg_req_i | input | 1 | Register access request |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rsp_valid_o | output | 1 | Response strobe |
| reg_rdata_o | output | 32 | Read data |
| reg_err_o | output | 1 | Response error flag |
| proc_err_o | output | 1 | Error-response strobe for processor-read fills |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acknowledge read and a capturable fill error arriving on the same clock edge. Neither the register bus nor the event port alone can set it up. The bench therefore drives the index-3 read and the event strobe in one cycle. It then checks that the interrupt drops and that the old address is still readable. Dropping a second error while one is pending is reached the same way: the bench issues two events back to back, with no acknowledge in between, and compares the address read back afterwards.

// File: rtl/fill_error_irq_pkg.sv
// Shared constants and types for the fill-error capture unit.
// Assumes a register address of function code above bit 7 and a 3-bit index.
package fill_error_irq_pkg;
    localparam int FUNC_LSB = 7;
    localparam int IDX_W    = 3;
    localparam int DATA_W   = 32;

    typedef enum logic [IDX_W-1:0] {
        IDX_ADDR_LO = 3'd0,
        IDX_ADDR_HI = 3'd1,
        IDX_SRCID   = 3'd2,
        IDX_IRQ_ACK = 3'd3,
        IDX_IRQ_EN  = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              err;
    } rsp_t;
endpackage

// File: rtl/fill_error_capture.sv
// Capture stage: holds one pending fill error with its byte address and source ID.
// Assumes 'clear' and 'enable' come from the register interface; clear beats a capture.
module fill_error_capture #(
    parameter int LINE_W = 34,
    parameter int SRC_W  = 14,
    parameter int WORDS  = 16,
    localparam int BYTES_PER_LINE = WORDS * 4,
    localparam int ADDR_W = LINE_W + $clog2(BYTES_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [LINE_W-1:0] evt_line,
    input  logic [SRC_W-1:0]  evt_srcid,
    input  logic              evt_fill,
    input  logic              evt_proc_read,
    input  logic              enable,
    input  logic              clear,
    output logic              pending,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [SRC_W-1:0]  cap_srcid,
    output logic              proc_err
);
    logic take;

    // Decide whether this cycle's event is recorded.
    always_comb begin
        take = evt_valid && evt_fill && !evt_proc_read && enable && !pending && !clear;
    end

    // Pending flag with clear priority, plus the processor-read error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            proc_err <= 1'b0;
        end else begin
            proc_err <= evt_valid && evt_proc_read;
            if (clear)
                pending <= 1'b0;
            else if (take)
                pending <= 1'b1;
        end
    end

    // Address and source ID latch, loaded only on a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_srcid <= '0;
        end else if (take) begin
            cap_addr  <= ADDR_W'(evt_line) * ADDR_W'(BYTES_PER_LINE);
            cap_srcid <= evt_srcid;
        end
    end
endmodule

// File: rtl/fill_error_regif.sv
// Register window: decodes function code and index, answers each request one cycle later.
// Assumes single-beat accesses; the reserved address bits must be zero.
module fill_error_regif
    import fill_error_irq_pkg::*;
#(
    parameter int REG_AW    = 10,
    parameter int FUNC_CODE = 2,
    parameter int ADDR_W    = 40,
    parameter int SRC_W     = 14,
    localparam int FUNC_W   = REG_AW - FUNC_LSB,
    localparam int RSV_W    = FUNC_LSB - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [SRC_W-1:0]  cap_srcid,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              enable,
    output logic              clear
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [63:0]      addr64;
    logic             en_wr;
    rsp_t             nxt;

    // Split the address into function, reserved and index fields.
    always_comb begin
        hit    = (addr[REG_AW-1:FUNC_LSB] == FUNC_W'(FUNC_CODE)) &&
                 (addr[FUNC_LSB-1:IDX_W] == RSV_W'(0));
        idx    = addr[IDX_W-1:0];
        addr64 = 64'(cap_addr);
    end

    // Compute the response contents and the side effects of this request.
    always_comb begin
        nxt   = '{data: '0, err: 1'b0};
        en_wr = 1'b0;
        clear = 1'b0;
        if (!hit) begin
            nxt.err = 1'b1;
        end else if (wr) begin
            if (idx == IDX_IRQ_EN) en_wr = req;
            else                   nxt.err = 1'b1;
        end else begin
            case (idx)
                IDX_ADDR_LO: nxt.data = addr64[31:0];
                IDX_ADDR_HI: nxt.data = addr64[63:32];
                IDX_SRCID:   nxt.data = DATA_W'(cap_srcid);
                IDX_IRQ_ACK: clear = req;
                default:     nxt.err = 1'b1;
            endcase
        end
    end

    // Register the response and the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            enable    <= 1'b0;
        end else begin
            rsp_valid <= req;
            if (req) begin
                rsp_rdata <= nxt.data;
                rsp_err   <= nxt.err;
            end
            if (en_wr)
                enable <= (wdata != '0);
        end
    end
endmodule

// File: rtl/fill_error_irq.sv
// Top: fill-error capture with maskable interrupt and register window.
// Assumes events and register requests are synchronous to clk.
module fill_error_irq #(
    parameter int LINE_W    = 34,
    parameter int SRC_W     = 14,
    parameter int WORDS     = 16,
    parameter int REG_AW    = 10,
    parameter int FUNC_CODE = 2,
    localparam int ADDR_W   = LINE_W + $clog2(WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    input  logic [LINE_W-1:0] evt_line_i,
    input  logic [SRC_W-1:0]  evt_srcid_i,
    input  logic              evt_fill_i,
    input  logic              evt_proc_read_i,
    input  logic              reg_req_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic              reg_rsp_valid_o,
    output logic [31:0]       reg_rdata_o,
    output logic              reg_err_o,
    output logic              proc_err_o,
    output logic              irq_o
);
    logic              pend_q;
    logic              en_q;
    logic              clr_w;
    logic [ADDR_W-1:0] cap_addr_w;
    logic [SRC_W-1:0]  cap_src_w;

    fill_error_capture #(.LINE_W(LINE_W), .SRC_W(SRC_W), .WORDS(WORDS)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid_i), .evt_line(evt_line_i), .evt_srcid(evt_srcid_i),
        .evt_fill(evt_fill_i), .evt_proc_read(evt_proc_read_i),
        .enable(en_q), .clear(clr_w),
        .pending(pend_q), .cap_addr(cap_addr_w), .cap_srcid(cap_src_w),
        .proc_err(proc_err_o)
    );

    fill_error_regif #(.REG_AW(REG_AW), .FUNC_CODE(FUNC_CODE), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) reg_i (
        .clk(clk), .rst_n(rst_n),
        .req(reg_req_i), .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
        .cap_addr(cap_addr_w), .cap_srcid(cap_src_w),
        .rsp_valid(reg_rsp_valid_o), .rsp_rdata(reg_rdata_o), .rsp_err(reg_err_o),
        .enable(en_q), .clear(clr_w)
    );

    // Interrupt is visible only while an error waits and interrupts are enabled.
    always_comb begin
        irq_o = pend_q && en_q;
    end
endmodule

// File: rtl/fill_error_irq_chk.sv
// Checker for fill_error_irq: temporal rules between the capture and register stages.
// Assumes it is bound into the top and sees its internal pending/enable/clear nets.
module fill_error_irq_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_fill,
    input logic              evt_proc_read,
    input logic              req,
    input logic              rsp_valid,
    input logic              proc_err,
    input logic              pending,
    input logic              enable,
    input logic              clear,
    input logic [ADDR_W-1:0] cap_addr
);
    AST_CAPTURE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_fill && !evt_proc_read && enable && !pending && !clear) |=> pending); // R2
    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> (pending && $stable(cap_addr))); // R5
    AST_PROC_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_proc_read) |=> proc_err); // R7
    AST_PROC_READ_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_proc_read && !pending) |=> !pending); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending); // R13
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid); // R12
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid); // R12
endmodule

bind fill_error_irq fill_error_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid_i), .evt_fill(evt_fill_i), .evt_proc_read(evt_proc_read_i),
    .req(reg_req_i), .rsp_valid(reg_rsp_valid_o), .proc_err(proc_err_o),
    .pending(pend_q), .enable(en_q), .clear(clr_w), .cap_addr(cap_addr_w)
);

// File: tb/fill_error_irq_tb_top.sv
// Scoreboard bench: access tasks queue expected responses, a monitor compares them.
module fill_error_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 34;
    localparam int SRC_W  = 14;
    localparam int REG_AW = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic [LINE_W-1:0] evt_line = '0;
    logic [SRC_W-1:0]  evt_srcid = '0;
    logic              evt_fill = 1'b0;
    logic              evt_proc_read = 1'b0;
    logic              req = 1'b0;
    logic              wr = 1'b0;
    logic [REG_AW-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rdata;
    logic              rsp_err;
    logic              proc_err;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic        e;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fill_error_irq dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid_i(evt_valid), .evt_line_i(evt_line), .evt_srcid_i(evt_srcid),
        .evt_fill_i(evt_fill), .evt_proc_read_i(evt_proc_read),
        .reg_req_i(req), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rsp_valid_o(rsp_valid), .reg_rdata_o(rdata), .reg_err_o(rsp_err),
        .proc_err_o(proc_err), .irq_o(irq)
    );

    function automatic void check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic logic [REG_AW-1:0] ra(int idx);
        return REG_AW'((2 << 7) | idx);
    endfunction

    // Monitor: pops the expected response for each one the design produces.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t x;
                x = sb_q.pop_front();
                check(rdata == x.d, {x.tag, " data"}, 64'(rdata), 64'(x.d));
                check(rsp_err == x.e, {x.tag, " err"}, 64'(rsp_err), 64'(x.e));
            end
        end
    end

    task automatic access(bit w, logic [REG_AW-1:0] a, logic [31:0] wd,
                          logic [31:0] ed, logic ee, string tag);
        exp_t x;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = wd;
        x.d = ed; x.e = ee; x.tag = tag;
        sb_q.push_back(x);
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic event_in(logic [LINE_W-1:0] line, logic [SRC_W-1:0] src, bit fill, bit pr);
        @(negedge clk);
        evt_valid = 1'b1; evt_line = line; evt_srcid = src; evt_fill = fill; evt_proc_read = pr;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    function automatic logic [63:0] baddr(logic [LINE_W-1:0] line);
        return 64'(line) * 64'd64;
    endfunction

    task automatic finish_test();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_test();
    end

    initial begin
        logic [LINE_W-1:0] l1 = 34'h2_ABCD_1234;
        logic [LINE_W-1:0] l2 = 34'h1_0000_0FF1;
        logic [LINE_W-1:0] l3 = 34'h0_5555_AAAA;
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'd0);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(proc_err == 1'b0, "R1 proc_err after reset", 64'(proc_err), 64'd0);
        rst_n = 1'b1;
        // R1: enable cleared by reset, so this error is not captured
        event_in(l1, 14'h11, 1'b1, 1'b0);
        check(irq == 1'b0, "R1 no capture while disabled", 64'(irq), 64'd0);
        access(1'b0, ra(0), 0, 32'd0, 1'b0, "R1 addr_lo empty");
        // R10: nonzero data enables
        access(1'b1, ra(4), 32'h5, 32'd0, 1'b0, "R10 enable write");
        // R7: processor-read fill error
        event_in(l1, 14'h12, 1'b1, 1'b1);
        check(proc_err == 1'b1, "R7 proc_err pulse", 64'(proc_err), 64'd1);
        check(irq == 1'b0, "R7 no irq", 64'(irq), 64'd0);
        @(negedge clk);
        check(proc_err == 1'b0, "R7 proc_err one cycle", 64'(proc_err), 64'd0);
        // R6: not a fill
        event_in(l1, 14'h13, 1'b0, 1'b0);
        check(irq == 1'b0, "R6 non-fill ignored", 64'(irq), 64'd0);
        // R2: real capture
        event_in(l1, 14'h2A5, 1'b1, 1'b0);
        check(irq == 1'b1, "R2 capture raises irq", 64'(irq), 64'd1);
        access(1'b0, ra(0), 0, baddr(l1)[31:0], 1'b0, "R3 addr_lo");
        access(1'b0, ra(1), 0, baddr(l1)[63:32], 1'b0, "R3 addr_hi");
        access(1'b0, ra(2), 0, 32'h2A5, 1'b0, "R4 srcid");
        // R5: second error dropped
        event_in(l2, 14'h3C, 1'b1, 1'b0);
        access(1'b0, ra(0), 0, baddr(l1)[31:0], 1'b0, "R5 addr kept");
        access(1'b0, ra(2), 0, 32'h2A5, 1'b0, "R5 srcid kept");
        // R8 / R10: mask and unmask
        access(1'b1, ra(4), 32'h0, 32'd0, 1'b0, "R10 disable write");
        check(irq == 1'b0, "R8 masked", 64'(irq), 64'd0);
        access(1'b1, ra(4), 32'h8000_0000, 32'd0, 1'b0, "R10 re-enable");
        check(irq == 1'b1, "R8 pending kept", 64'(irq), 64'd1);
        // R9: acknowledge
        access(1'b0, ra(3), 0, 32'd0, 1'b0, "R9 ack read");
        check(irq == 1'b0, "R9 ack clears", 64'(irq), 64'd0);
        event_in(l2, 14'h3C, 1'b1, 1'b0);
        check(irq == 1'b1, "R2 capture after ack", 64'(irq), 64'd1);
        access(1'b0, ra(0), 0, baddr(l2)[31:0], 1'b0, "R3 addr_lo second");
        access(1'b0, ra(1), 0, baddr(l2)[63:32], 1'b0, "R3 addr_hi second");
        // R13: ack and event in the same cycle
        fork
            access(1'b0, ra(3), 0, 32'd0, 1'b0, "R13 ack");
            event_in(l3, 14'h7, 1'b1, 1'b0);
        join
        check(irq == 1'b0, "R13 event dropped", 64'(irq), 64'd0);
        access(1'b0, ra(0), 0, baddr(l2)[31:0], 1'b0, "R13 old addr kept");
        // R11: error responses
        access(1'b1, ra(0), 32'h1, 32'd0, 1'b1, "R11 write ro index");
        access(1'b1, ra(3), 32'h1, 32'd0, 1'b1, "R11 write ack index");
        access(1'b0, ra(4), 0, 32'd0, 1'b1, "R11 read enable index");
        access(1'b0, ra(7), 0, 32'd0, 1'b1, "R11 read index 7");
        access(1'b0, REG_AW'((1 << 7) | 0), 0, 32'd0, 1'b1, "R11 wrong function");
        access(1'b0, REG_AW'((2 << 7) | (1 << 3)), 0, 32'd0, 1'b1, "R11 reserved bits");
        // R12: no response while idle
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R12 idle no response", 64'(rsp_valid), 64'd0);
        check(sb_q.size() == 0, "R12 all responses seen", 64'(sb_q.size()), 64'd0);
        finish_test();
    end
endmodule